// File: doc/BRIEF.md
# Stereo Audio Serial Output Port

This block transmits stereo audio as a stream of 18-bit two's-complement words over a three-wire serial link: a bit clock, a word clock that marks left and right halves of each frame, and a data line. Samples arrive as left/right pairs on a parallel input with a valid/ready handshake. A one-entry holding register takes a pair, and the pair is moved into the transmit path only when a left half-frame begins. Both words of one frame therefore come from the same sampling instant. If no fresh pair has arrived by then, the previous pair is sent again.

The port runs in one of two modes, picked by a strap level seen on the data pin once, when reset is released. As a slave it follows an external bit clock and word clock. Both are sampled into the system clock domain and edge-detected. Any bit-clock rate from 32 to 64 times the word rate is accepted: half-frames that are too short lose their LSBs, and half-frames that are too long are padded with zeros. As a master, the system clock acts as a master clock at 256 times the sample rate. One free-running counter divides it down to a bit clock at 64 times the word rate and to the word clock, and the port drives both.

Timing is left-justified. The word clock is low for the left word and high for the right word. The MSB goes out on the first falling bit-clock edge at or after each word-clock transition.

Top module: `stx_serial_tx`

## Requirements
- R1: The strap input is captured on the first clock edge with `rst_n` high. A high level selects master mode and a low level selects slave mode. `sdata_oe` stays low until that capture, goes high one cycle after reset release, and later strap changes have no effect on the mode.
- R2: In master mode `bclk_oe` and `wclk_oe` are high. `bclk_o` has a period of 4 system clocks. `wclk_o` changes only together with a falling `bclk_o` edge and holds each level for 32 bit-clock periods. In slave mode both clock enables stay low.
- R3: A low word-clock level carries the left sample and a high level carries the right sample.
- R4: Each word is sent MSB first, one bit per bit-clock period. Bit 17 is driven from the first falling bit-clock edge at or after a word-clock transition, and bit 17-i from the i-th falling edge after that.
- R5: `sdata_o` changes only after a falling bit-clock edge: one system clock later in master mode, and three system clocks later in slave mode (two synchronizer stages plus one register). It holds its value through the rest of the bit period.
- R6: When a half-frame has fewer than 18 bit clocks, only the leading bits are sent and the next word still starts with its own MSB.
- R7: When a half-frame has more than 18 bit clocks, `sdata_o` is 0 after the LSB until the next word-clock transition.
- R8: In slave mode every bit-clock count per frame from 32 to 64 is handled. An odd count gives the left half floor(N/2) bits.
- R9: A pair accepted on the parallel input reaches the link only at the next left half-frame start. A pair that arrives during a left half does not change the right word of that frame.
- R10: If no new pair is held when a left half-frame starts, the previous pair is sent again.
- R11: `in_ready` is high when the holding register is empty. After a transfer (`in_valid` and `in_ready` both high) it is low until the held pair is taken at a left half-frame start.
- R12: During reset `sdata_o`, `sdata_oe`, `bclk_oe` and `wclk_oe` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the master clock in master mode |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A stereo pair is offered on `in_left`/`in_right` |
| in_ready | output | 1 | Holding register is empty and can take a pair |
| in_left | input | 18 | Left sample, two's complement |
| in_right | input | 18 | Right sample, two's complement |
| bclk_i | input | 1 | External bit clock (slave mode) |
| wclk_i | input | 1 | External word clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| bclk_oe | output | 1 | Drive enable for the bit-clock pin |
| wclk_o | output | 1 | Generated word clock (master mode) |
| wclk_oe | output | 1 | Drive enable for the word-clock pin |
| sdata_strap_i | input | 1 | Level on the data pin, read as the mode strap |
| sdata_o | output | 1 | Serial data |
| sdata_oe | output | 1 | Drive enable for the data pin |

## Verification
In slave mode the bench sweeps every frame length from 32 to 64 bit clocks, odd lengths included. A port that miscounted bits would shift the words, keep the 16-bit halves from restarting at the MSB, or leak old LSBs into the zero padding. It also places a new pair in the middle of a left half. A port that latched on arrival rather than at the left start would send a right word that does not match the left word of the same frame. In master mode the bench measures the bit-clock period and the half-frame length, and checks that pairs repeat when nothing new arrives. A strap that was read continuously rather than once would flip the clock drive enables partway through the run.

// File: rtl/stx_pkg.sv
// Shared types for the stereo serial transmitter.
// Assumes an 18-bit two's-complement sample for each channel.
package stx_pkg;
    localparam int unsigned SAMPLE_W = 18;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } stereo_pair_t;

    typedef enum logic {
        MODE_SLAVE  = 1'b0,
        MODE_MASTER = 1'b1
    } port_mode_e;
endpackage

// File: rtl/stx_strap.sv
// Captures the mode strap once, on the first clock edge after reset release.
// Assumes the strap level is stable around that edge.
module stx_strap
    import stx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_i,
    output logic       done_o,
    output port_mode_e mode_o
);
    // Single-shot capture of the strap; frozen afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            mode_o <= MODE_SLAVE;
        end else if (!done_o) begin
            done_o <= 1'b1;
            mode_o <= strap_i ? MODE_MASTER : MODE_SLAVE;
        end
    end
endmodule

// File: rtl/stx_clkgen.sv
// Master-mode clock generator: one counter gives both the bit clock and the
// word clock, so the word clock always toggles with a falling bit clock.
// Assumes MCLK_PER_BIT and BITS_PER_FRAME are powers of two, MCLK_PER_BIT >= 2.
module stx_clkgen #(
    parameter int unsigned MCLK_PER_BIT   = 4,
    parameter int unsigned BITS_PER_FRAME = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic bclk_o,
    output logic wclk_o
);
    localparam int unsigned DIV_LOG = $clog2(MCLK_PER_BIT);
    localparam int unsigned CNT_W   = DIV_LOG + $clog2(BITS_PER_FRAME);

    logic [CNT_W-1:0] cnt_q;

    // Free-running divider, held at zero until master mode is confirmed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign bclk_o = cnt_q[DIV_LOG-1];
    assign wclk_o = cnt_q[CNT_W-1];
endmodule

// File: rtl/stx_edge.sv
// Serial clock front end: synchronizes the external clock, chooses between it
// and the internally generated one, and keeps the previous level so the parent
// can find edges. Assumes SYNC_STAGES >= 2.
module stx_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_i,
    input  logic int_i,
    input  logic use_int,
    output logic level_o,
    output logic prev_o
);
    logic [SYNC_STAGES-1:0] sync_q;

    // Synchronizer chain for the externally driven clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ext_i};
        end
    end

    // Source select: the internal clock is already in this domain.
    always_comb begin
        level_o = use_int ? int_i : sync_q[SYNC_STAGES-1];
    end

    // One-cycle history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_o <= 1'b0;
        end else begin
            prev_o <= level_o;
        end
    end
endmodule

// File: rtl/stx_pair_buf.sv
// One-entry holding register for stereo pairs plus the pair in transmission.
// The held pair moves to the current pair only when take_i (left start) fires.
module stx_pair_buf
    import stx_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  sample_t      in_left,
    input  sample_t      in_right,
    input  logic         take_i,
    output stereo_pair_t pair_o
);
    stereo_pair_t next_q;
    stereo_pair_t cur_q;
    logic         full_q;

    assign in_ready = !full_q;

    // Accept into the holding slot; hand over at a left half-frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= '0;
            cur_q  <= '0;
            full_q <= 1'b0;
        end else begin
            if (take_i && full_q) begin
                cur_q  <= next_q;
                full_q <= 1'b0;
            end else if (in_valid && !full_q) begin
                next_q <= '{left: in_left, right: in_right};
                full_q <= 1'b1;
            end
        end
    end

    // The pair in force this cycle, including one taken in this very cycle.
    always_comb begin
        pair_o = (take_i && full_q) ? next_q : cur_q;
    end
endmodule

// File: rtl/stx_shifter.sv
// Left-justified word serializer. A word-clock change arms a new word; the MSB
// leaves on the first bit-clock fall at or after it, then one bit per fall,
// then zeros until the next word-clock change.
module stx_shifter
    import stx_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         bfall_i,
    input  logic         wchg_i,
    input  logic         wlevel_i,
    input  stereo_pair_t pair_i,
    output logic         sdata_o
);
    localparam int unsigned IDX_W = $clog2(SAMPLE_W + 1);

    logic             pending_q;
    logic             chan_q;
    sample_t          shreg_q;
    logic [IDX_W-1:0] idx_q;
    logic             start;
    logic             chan;
    sample_t          first_word;

    // Word selection for a start occurring in this cycle.
    always_comb begin
        start      = pending_q | wchg_i;
        chan       = wchg_i ? wlevel_i : chan_q;
        first_word = chan ? pair_i.right : pair_i.left;
    end

    // Bit sequencing on bit-clock falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            chan_q    <= 1'b0;
            shreg_q   <= '0;
            idx_q     <= IDX_W'(SAMPLE_W);
            sdata_o   <= 1'b0;
        end else if (en) begin
            if (wchg_i) begin
                chan_q <= wlevel_i;
            end
            if (bfall_i) begin
                pending_q <= 1'b0;
                if (start) begin
                    sdata_o <= first_word[SAMPLE_W-1];
                    shreg_q <= first_word << 1;
                    idx_q   <= IDX_W'(1);
                end else if (idx_q < IDX_W'(SAMPLE_W)) begin
                    sdata_o <= shreg_q[SAMPLE_W-1];
                    shreg_q <= shreg_q << 1;
                    idx_q   <= idx_q + IDX_W'(1);
                end else begin
                    sdata_o <= 1'b0;
                end
            end else if (wchg_i) begin
                pending_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/stx_serial_tx.sv
// Stereo serial output port, top level. Assumes clk is the master clock
// (256x the sample rate) in master mode, and at least several times the
// external bit clock in slave mode.
module stx_serial_tx
    import stx_pkg::*;
#(
    parameter int unsigned MCLK_PER_BIT   = 4,
    parameter int unsigned BITS_PER_FRAME = 64,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic                bclk_i,
    input  logic                wclk_i,
    output logic                bclk_o,
    output logic                bclk_oe,
    output logic                wclk_o,
    output logic                wclk_oe,
    input  logic                sdata_strap_i,
    output logic                sdata_o,
    output logic                sdata_oe
);
    logic         strap_done;
    port_mode_e   mode;
    logic         master;
    logic         b_lvl, b_prev, w_lvl, w_prev;
    logic         b_fall, w_chg, w_fall;
    stereo_pair_t pair;

    stx_strap u_strap (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap_i (sdata_strap_i),
        .done_o  (strap_done),
        .mode_o  (mode)
    );

    assign master = strap_done && (mode == MODE_MASTER);

    stx_clkgen #(
        .MCLK_PER_BIT   (MCLK_PER_BIT),
        .BITS_PER_FRAME (BITS_PER_FRAME)
    ) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (master),
        .bclk_o (bclk_o),
        .wclk_o (wclk_o)
    );

    stx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_bedge (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_i   (bclk_i),
        .int_i   (bclk_o),
        .use_int (master),
        .level_o (b_lvl),
        .prev_o  (b_prev)
    );

    stx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_wedge (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_i   (wclk_i),
        .int_i   (wclk_o),
        .use_int (master),
        .level_o (w_lvl),
        .prev_o  (w_prev)
    );

    // Edge events on the selected serial clocks.
    always_comb begin
        b_fall = b_prev & ~b_lvl;
        w_chg  = w_prev ^ w_lvl;
        w_fall = w_chg & ~w_lvl;
    end

    stx_pair_buf u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_left  (in_left),
        .in_right (in_right),
        .take_i   (strap_done & w_fall),
        .pair_o   (pair)
    );

    stx_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (strap_done),
        .bfall_i  (b_fall),
        .wchg_i   (w_chg),
        .wlevel_i (w_lvl),
        .pair_i   (pair),
        .sdata_o  (sdata_o)
    );

    // Pin drive enables follow the captured mode.
    always_comb begin
        bclk_oe  = master;
        wclk_oe  = master;
        sdata_oe = strap_done;
    end
endmodule

// File: rtl/stx_serial_tx_chk.sv
// Temporal checks for stx_serial_tx, attached by bind.
module stx_serial_tx_chk #(
    parameter int unsigned BITS_PER_FRAME = 64
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic sdata_o,
    input logic sdata_oe,
    input logic bclk_o,
    input logic wclk_o,
    input logic strap_done,
    input logic master,
    input logic b_fall
);
    localparam int unsigned HALF  = BITS_PER_FRAME / 2;
    localparam int unsigned CNT_W = $clog2(BITS_PER_FRAME) + 1;

    logic             bprev_q, wprev_q, seen_q;
    logic [CNT_W-1:0] fcnt_q;

    // Counts generated bit-clock falls inside each word-clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bprev_q <= 1'b0;
            wprev_q <= 1'b0;
            seen_q  <= 1'b0;
            fcnt_q  <= '0;
        end else begin
            bprev_q <= bclk_o;
            wprev_q <= wclk_o;
            if (wclk_o != wprev_q) begin
                fcnt_q <= '0;
                seen_q <= 1'b1;
            end else if (bprev_q && !bclk_o) begin
                fcnt_q <= fcnt_q + CNT_W'(1);
            end
        end
    end

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        strap_done |=> $stable(master)); // R1
    AST_OE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        sdata_oe |=> sdata_oe); // R1
    AST_WCK_ON_BFALL: assert property (@(posedge clk) disable iff (!rst_n)
        (master && (wclk_o != wprev_q)) |-> (bprev_q && !bclk_o)); // R2
    AST_HALF_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (master && seen_q && (wclk_o != wprev_q)) |-> (fcnt_q == CNT_W'(HALF - 1))); // R2
    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata_o) |-> $past(b_fall)); // R5
    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R11
endmodule

bind stx_serial_tx stx_serial_tx_chk #(.BITS_PER_FRAME(BITS_PER_FRAME)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .sdata_o    (sdata_o),
    .sdata_oe   (sdata_oe),
    .bclk_o     (bclk_o),
    .wclk_o     (wclk_o),
    .strap_done (strap_done),
    .master     (master),
    .b_fall     (b_fall)
);

// File: tb/stx_serial_tx_bench.sv
module stx_serial_tx_bench;
    import stx_pkg::*;

    localparam int H = 8;  // slave bit-clock half period, in system clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [17:0] in_left = '0;
    logic [17:0] in_right = '0;
    logic        bclk_i = 1'b0;
    logic        wclk_i = 1'b0;
    logic        bclk_o, bclk_oe, wclk_o, wclk_oe;
    logic        sdata_strap_i = 1'b0;
    logic        sdata_o, sdata_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    stx_serial_tx u_stx_serial_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_left       (in_left),
        .in_right      (in_right),
        .bclk_i        (bclk_i),
        .wclk_i        (wclk_i),
        .bclk_o        (bclk_o),
        .bclk_oe       (bclk_oe),
        .wclk_o        (wclk_o),
        .wclk_oe       (wclk_oe),
        .sdata_strap_i (sdata_strap_i),
        .sdata_o       (sdata_o),
        .sdata_oe      (sdata_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic stereo_pair_t mk_pair(input int seed);
        stereo_pair_t p;
        p.left  = 18'(seed * 10007 + 3);
        p.right = p.left ^ 18'h2AAAA;
        return p;
    endfunction

    task automatic do_reset(input logic strap);
        rst_n = 1'b0;
        sdata_strap_i = strap;
        bclk_i = 1'b0;
        wclk_i = 1'b0;
        in_valid = 1'b0;
        repeat (5) @(negedge clk);
        chk("R12 sdata_o", int'(sdata_o), 0);
        chk("R12 sdata_oe", int'(sdata_oe), 0);
        chk("R12 bclk_oe", int'(bclk_oe), 0);
        chk("R12 wclk_oe", int'(wclk_oe), 0);
        chk("R12 in_ready", int'(in_ready), 1);
        rst_n = 1'b1;
        chk("R1 oe before capture", int'(sdata_oe), 0);
        @(negedge clk);
        chk("R1 oe after capture", int'(sdata_oe), 1);
        chk("R2 bclk_oe by mode", int'(bclk_oe), int'(strap));
        chk("R2 wclk_oe by mode", int'(wclk_oe), int'(strap));
    endtask

    task automatic push(input stereo_pair_t p);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_left  = p.left;
        in_right = p.right;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R11 ready low while held", int'(in_ready), 0);
    endtask

    // One slave half-frame of n bits; word clock set to w on its first fall.
    task automatic slave_half(input logic w, input int n, input logic [17:0] word, input string base);
        for (int i = 0; i < n; i++) begin
            int    exp;
            int    got;
            string tag;
            bclk_i = 1'b0;
            if (i == 0) wclk_i = w;
            repeat (H) @(negedge clk);
            exp = (i < 18) ? int'(word[17-i]) : 0;
            tag = (i >= 18) ? "R7" : ((n < 18) ? "R6" : "R4");
            got = int'(sdata_o);
            chk($sformatf("%s %s n=%0d bit=%0d", base, tag, n, i), got, exp);
            bclk_i = 1'b1;
            repeat (H) @(negedge clk);
            chk($sformatf("R5 hold n=%0d bit=%0d", n, i), int'(sdata_o), got);
        end
    endtask

    task automatic slave_frame(input int n, input stereo_pair_t p, input string base);
        slave_half(1'b0, n / 2, p.left, base);
        slave_half(1'b1, n - n / 2, p.right, base);
    endtask

    // Collect one master half-frame that starts at the current negedge.
    task automatic master_half(input logic lvl, input logic [17:0] word, input string base);
        int   nbits = 0;
        int   ncyc = 0;
        logic pb = bclk_o;
        forever begin
            @(negedge clk);
            ncyc++;
            if (wclk_o != lvl) break;
            if (bclk_o && !pb) begin
                chk($sformatf("%s %s bit=%0d", base, (nbits >= 18) ? "R7" : "R4", nbits),
                    int'(sdata_o), (nbits < 18) ? int'(word[17-nbits]) : 0);
                nbits++;
            end
            pb = bclk_o;
        end
        chk("R2 bits per half", nbits, 32);
        chk("R2 clocks per half", ncyc, 128);
    endtask

    task automatic master_frame(input stereo_pair_t p, input string base);
        while (wclk_o !== 1'b1) @(negedge clk);
        while (wclk_o !== 1'b0) @(negedge clk);
        master_half(1'b0, p.left, base);
        master_half(1'b1, p.right, base);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        stereo_pair_t prev;
        stereo_pair_t q;

        // ---------------- slave mode ----------------
        do_reset(1'b0);
        sdata_strap_i = 1'b1;             // R1: later strap change must be ignored
        bclk_i = 1'b1;
        repeat (H) @(negedge clk);
        slave_half(1'b1, 20, 18'h0, "R3 prime");
        prev = mk_pair(1);
        push(prev);
        slave_frame(64, prev, "R3 R8");
        for (int n = 32; n < 64; n++) begin
            prev = mk_pair(n);
            push(prev);
            slave_frame(n, prev, "R3 R8");
        end
        slave_frame(40, prev, "R10 repeat");
        q = mk_pair(777);
        fork
            slave_half(1'b0, 24, prev.left, "R9 left");
            begin
                repeat (100) @(negedge clk);
                push(q);
            end
        join
        slave_half(1'b1, 24, prev.right, "R9 right same pair");
        slave_frame(48, q, "R9 new pair");
        chk("R1 strap ignored after capture", int'(bclk_oe), 0);

        // ---------------- master mode ----------------
        do_reset(1'b1);
        sdata_strap_i = 1'b0;
        prev = mk_pair(91);
        push(prev);
        master_frame(prev, "R2 R3");
        master_frame(prev, "R10 master repeat");
        q = mk_pair(1234);
        push(q);
        master_frame(q, "R9 master new");
        chk("R1 strap ignored master", int'(bclk_oe), 1);
        chk("R2 wclk_oe master", int'(wclk_oe), 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule